// File: doc/BRIEF.md
# Processor Interrupt Entry Controller

This block sits beside a small 32-bit processor core. It collects 32 level-sensitive external interrupt request lines into a sticky pending register. Each instruction boundary the core reports is a point where the block may start an interrupt. A software mask register and a global enable bit decide whether the pending requests may be serviced. When the core signals that an instruction has finished and a serviceable request exists, the block starts exception entry. It gives the core a return address to write into general register 30 and a new program counter. It also sets its own enable register to a fixed value, which turns off further entries.

Software reads and writes four registers through a simple select/write-enable port: the pending register (write-one-to-clear), the mask, the two-bit enable register and the exception base address. A request that is masked or disabled when it arrives stays pending. It is taken at the first later boundary after software unmasks or enables it.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset the pending, mask, enable and base registers all read zero and take_irq is low.
- R2: While request line n is high, pending bit n becomes 1 at the next clock edge. The bit stays 1 after the line drops.
- R3: A register write with csr_sel=0 clears every pending bit whose csr_wdata bit is 1 and leaves the others alone. If a line is high in the same cycle as a clear of its bit, the bit stays set.
- R4: csr_sel=1 selects the mask, csr_sel=2 the enable register (bits 1:0 stored, upper bits read zero) and csr_sel=3 the base address. The base stores bits 31:8, and bits 7:0 always read zero.
- R5: No entry is started in a cycle where instr_boundary is low.
- R6: Entry starts at a boundary only if (pending AND mask) is non-zero and enable bit 0 is 1.
- R7: take_irq goes high for exactly one cycle, in the cycle after the boundary cycle that started entry. new_pc then equals base + 6*32.
- R8: While take_irq is high, gr_idx is 30 and gr_data equals the cur_pc value present in the boundary cycle.
- R9: Entry writes 0x2 into the enable register. If software writes the enable register in the same cycle, the entry value wins.
- R10: A request that is pending but masked or disabled at a boundary is taken at a later boundary once it is unmasked and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines | input | 32 | Level-sensitive interrupt requests |
| instr_boundary | input | 1 | Strobe from the core: current instruction is complete |
| cur_pc | input | 32 | Program counter of the interrupted instruction |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select: 0 pending, 1 mask, 2 enable, 3 base |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data of the selected register |
| take_irq | output | 1 | One-cycle exception entry pulse |
| new_pc | output | 32 | Vector address for the core |
| gr_idx | output | 5 | Index of the general register that receives the return address |
| gr_data | output | 32 | Return address to write |

## Verification
Assertions check the following on every cycle: a high line always sets its pending bit, and a pending bit never drops except through a software clear. They also check that an entry pulse always has a boundary and a serviceable, enabled request one cycle earlier, that the pulse lasts one cycle, and that the enable register holds 0x2 after every entry. The exact vector and return-address values need the bench's scenarios. So do the set-over-clear collision, the loss of a software enable write to a simultaneous entry, and a masked or disabled request being taken later. The bench sweeps every request line through latch, hold, clear and entry.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_MASK = 2'd1,
    SEL_ENAB = 2'd2,
    SEL_BASE = 2'd3
  } csr_sel_e;

  // enable register layout: bit 0 global enable, bit 1 saved enable
  localparam int unsigned ENAB_W     = 2;
  localparam logic [1:0]  ENAB_ENTRY = 2'b10;
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int unsigned N_IRQ = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             clr_en_i,
  input  logic [N_IRQ-1:0] clr_mask_i,
  output logic [N_IRQ-1:0] pend_o
);
  logic [N_IRQ-1:0] pend_q;
  logic [N_IRQ-1:0] pend_d;
  logic [N_IRQ-1:0] clr_vec;

  always_comb begin
    clr_vec = clr_en_i ? clr_mask_i : '0;
    // set takes priority over a same-cycle clear
    pend_d  = (pend_q & ~clr_vec) | irq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  p_line_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i != '0) |=> ((pend_q & $past(irq_i)) == $past(irq_i)));

  p_only_sw_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0) |=> (($past(pend_q) & ~pend_q & ~$past(clr_vec)) == '0));
endmodule

// File: rtl/irq_csr_regs.sv
module irq_csr_regs
  import irq_entry_pkg::*;
#(
  parameter int unsigned N_IRQ     = 32,
  parameter int unsigned XLEN      = 32,
  parameter int unsigned BASE_ZERO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  csr_sel_e          sel_i,
  input  logic [XLEN-1:0]   wdata_i,
  input  logic              entry_i,
  output logic [N_IRQ-1:0]  mask_o,
  output logic [ENAB_W-1:0] enab_o,
  output logic [XLEN-1:0]   base_o
);
  localparam int unsigned BASE_HI = XLEN - BASE_ZERO;

  logic [N_IRQ-1:0]   mask_q, mask_d;
  logic [ENAB_W-1:0]  enab_q, enab_d;
  logic [BASE_HI-1:0] base_q, base_d;
  logic               mask_ce, enab_ce, base_ce;

  always_comb begin
    mask_ce = wr_en_i && (sel_i == SEL_MASK);
    base_ce = wr_en_i && (sel_i == SEL_BASE);
    enab_ce = entry_i || (wr_en_i && (sel_i == SEL_ENAB));
    mask_d  = wdata_i[N_IRQ-1:0];
    base_d  = wdata_i[XLEN-1:BASE_ZERO];
    // hardware entry overrides a simultaneous software write
    enab_d  = entry_i ? ENAB_ENTRY : wdata_i[ENAB_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_ce) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       enab_q <= '0;
    else if (enab_ce) enab_q <= enab_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_ce) base_q <= base_d;
  end

  assign mask_o = mask_q;
  assign enab_o = enab_q;
  assign base_o = {base_q, {BASE_ZERO{1'b0}}};

  p_entry_enab_r9: assert property (@(posedge clk) disable iff (!rst_n)
    entry_i |=> (enab_q == ENAB_ENTRY));

  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && (sel_i == SEL_MASK)) |=> (mask_q == $past(mask_q)));
endmodule

// File: rtl/irq_entry_decide.sv
module irq_entry_decide #(
  parameter int unsigned N_IRQ     = 32,
  parameter int unsigned XLEN      = 32,
  parameter int unsigned EXC_ID    = 6,
  parameter int unsigned VEC_SHIFT = 5,
  parameter int unsigned RA_REG    = 30,
  parameter int unsigned GR_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [N_IRQ-1:0] pend_i,
  input  logic [N_IRQ-1:0] mask_i,
  input  logic             ie_i,
  input  logic [XLEN-1:0]  base_i,
  output logic             entry_o,
  output logic             take_o,
  output logic [XLEN-1:0]  vec_o,
  output logic [GR_W-1:0]  ra_idx_o,
  output logic [XLEN-1:0]  ra_data_o
);
  localparam logic [XLEN-1:0] VEC_OFS = XLEN'(EXC_ID) << VEC_SHIFT;

  logic            serviceable;
  logic            take_q, take_d;
  logic [XLEN-1:0] vec_q, vec_d;
  logic [XLEN-1:0] ra_q, ra_d;

  always_comb begin
    serviceable = ie_i && ((pend_i & mask_i) != '0);
    take_d      = boundary_i && serviceable;
    vec_d       = base_i + VEC_OFS;
    ra_d        = pc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) take_q <= 1'b0;
    else        take_q <= take_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      ra_q  <= '0;
    end else if (take_d) begin
      vec_q <= vec_d;
      ra_q  <= ra_d;
    end
  end

  assign entry_o   = take_d;
  assign take_o    = take_q;
  assign vec_o     = vec_q;
  assign ra_data_o = ra_q;
  assign ra_idx_o  = GR_W'(RA_REG);

  p_take_needs_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> $past(boundary_i));

  p_take_qualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> ($past(ie_i) && ($past(pend_i & mask_i) != '0)));

  p_take_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |=> !take_q);
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int unsigned N_IRQ     = 32,
  parameter int unsigned XLEN      = 32,
  parameter int unsigned EXC_ID    = 6,
  parameter int unsigned VEC_SHIFT = 5,
  parameter int unsigned RA_REG    = 30,
  parameter int unsigned GR_W      = 5,
  parameter int unsigned BASE_ZERO = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_lines,
  input  logic             instr_boundary,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic             csr_we,
  input  logic [1:0]       csr_sel,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  csr_rdata,
  output logic             take_irq,
  output logic [XLEN-1:0]  new_pc,
  output logic [GR_W-1:0]  gr_idx,
  output logic [XLEN-1:0]  gr_data
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  csr_sel_e          sel;
  logic [N_IRQ-1:0]  pend, mask;
  logic [ENAB_W-1:0] enab;
  logic [XLEN-1:0]   base;
  logic              entry;
  logic              pend_clr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign sel      = csr_sel_e'(csr_sel);
  assign pend_clr = csr_we && (sel == SEL_PEND);

  irq_pend_latch #(.N_IRQ(N_IRQ)) u_pend (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .irq_i     (irq_lines),
    .clr_en_i  (pend_clr),
    .clr_mask_i(csr_wdata[N_IRQ-1:0]),
    .pend_o    (pend)
  );

  irq_csr_regs #(.N_IRQ(N_IRQ), .XLEN(XLEN), .BASE_ZERO(BASE_ZERO)) u_csr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en_i(csr_we),
    .sel_i  (sel),
    .wdata_i(csr_wdata),
    .entry_i(entry),
    .mask_o (mask),
    .enab_o (enab),
    .base_o (base)
  );

  irq_entry_decide #(
    .N_IRQ(N_IRQ), .XLEN(XLEN), .EXC_ID(EXC_ID),
    .VEC_SHIFT(VEC_SHIFT), .RA_REG(RA_REG), .GR_W(GR_W)
  ) u_decide (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .boundary_i(instr_boundary),
    .pc_i      (cur_pc),
    .pend_i    (pend),
    .mask_i    (mask),
    .ie_i      (enab[0]),
    .base_i    (base),
    .entry_o   (entry),
    .take_o    (take_irq),
    .vec_o     (new_pc),
    .ra_idx_o  (gr_idx),
    .ra_data_o (gr_data)
  );

  always_comb begin
    unique case (sel)
      SEL_PEND: csr_rdata = XLEN'(pend);
      SEL_MASK: csr_rdata = XLEN'(mask);
      SEL_ENAB: csr_rdata = XLEN'(enab);
      default:  csr_rdata = base;
    endcase
  end
endmodule

// File: tb/sim_irq_entry_ctrl.sv
`timescale 1ns/1ps
module sim_irq_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_lines;
  logic        instr_boundary;
  logic [31:0] cur_pc;
  logic        csr_we;
  logic [1:0]  csr_sel;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic        take_irq;
  logic [31:0] new_pc;
  logic [4:0]  gr_idx;
  logic [31:0] gr_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irq_entry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .instr_boundary(instr_boundary), .cur_pc(cur_pc),
    .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .take_irq(take_irq), .new_pc(new_pc),
    .gr_idx(gr_idx), .gr_data(gr_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    csr_sel = sel;
    #0.5;
    v = csr_rdata;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    csr_sel = sel; csr_wdata = d; csr_we = 1'b1;
    step();
    csr_we = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; irq_lines = '0; instr_boundary = 1'b0; cur_pc = '0;
    csr_we = 1'b0; csr_sel = 2'd0; csr_wdata = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v); check("R1 reset reg", v, 32'h0);
    end
    check("R1 take low", {31'b0, take_irq}, 32'h0);

    // R4 register access
    wr(2'd1, 32'hA5C3_0F1E); rd(2'd1, v); check("R4 mask rw", v, 32'hA5C3_0F1E);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); check("R4 enab width", v, 32'h3);
    wr(2'd2, 32'h0);
    wr(2'd3, 32'h1234_5678); rd(2'd3, v); check("R4 base low zero", v, 32'h1234_5600);
    wr(2'd1, 32'h0);

    // R2 / R3 sweep every line: set, hold, clear
    for (int n = 0; n < 32; n++) begin
      irq_lines = 32'h1 << n; step(); irq_lines = '0; step();
      rd(2'd0, v); check("R2 sticky set", v, 32'h1 << n);
      wr(2'd0, ~(32'h1 << n)); rd(2'd0, v); check("R3 other bits kept", v, 32'h1 << n);
      wr(2'd0, 32'h1 << n);    rd(2'd0, v); check("R3 w1c clears", v, 32'h0);
    end

    // R3 set wins over clear in the same cycle
    irq_lines = 32'h0000_0100; step();
    csr_sel = 2'd0; csr_wdata = 32'h0000_0100; csr_we = 1'b1; step();
    csr_we = 1'b0; irq_lines = '0;
    rd(2'd0, v); check("R3 set wins", v, 32'h0000_0100);
    wr(2'd0, 32'h0000_0100); rd(2'd0, v); check("R3 clear after drop", v, 32'h0);

    // R6 / R7 / R8 / R9 entry sweep over every line
    for (int n = 0; n < 32; n++) begin
      logic [31:0] b;
      b = 32'(n) << 27 | 32'h0000_1F00;
      wr(2'd3, b);
      irq_lines = 32'h1 << n; step(); irq_lines = '0;
      wr(2'd1, 32'h1 << n);
      wr(2'd2, 32'h1);
      // R5: no boundary, no entry
      step(); check("R5 no boundary", {31'b0, take_irq}, 32'h0);
      cur_pc = 32'h8000_0000 | (32'(n) << 4);
      instr_boundary = 1'b1; step(); instr_boundary = 1'b0; cur_pc = '0;
      check("R7 take pulse", {31'b0, take_irq}, 32'h1);
      check("R7 vector", new_pc, b + 32'd192);
      check("R8 ra index", {27'b0, gr_idx}, 32'd30);
      check("R8 ra data", gr_data, 32'h8000_0000 | (32'(n) << 4));
      rd(2'd2, v); check("R9 enab after entry", v, 32'h2);
      step(); check("R7 one cycle", {31'b0, take_irq}, 32'h0);
      wr(2'd0, 32'hFFFF_FFFF); wr(2'd1, 32'h0); wr(2'd2, 32'h0);
    end

    // R6 / R10 masked then unmasked, disabled then enabled
    irq_lines = 32'h0000_0004; step(); irq_lines = '0;
    wr(2'd1, 32'hFFFF_FFFB); wr(2'd2, 32'h1);
    instr_boundary = 1'b1; step(); instr_boundary = 1'b0;
    check("R6 masked no take", {31'b0, take_irq}, 32'h0);
    wr(2'd1, 32'h0000_0004); wr(2'd2, 32'h0);
    instr_boundary = 1'b1; step(); instr_boundary = 1'b0;
    check("R6 disabled no take", {31'b0, take_irq}, 32'h0);
    wr(2'd2, 32'h1);
    cur_pc = 32'h0000_4444;
    instr_boundary = 1'b1; step(); instr_boundary = 1'b0;
    check("R10 later take", {31'b0, take_irq}, 32'h1);
    check("R10 ra data", gr_data, 32'h0000_4444);
    step();
    // entry disabled itself: no second take on a new boundary
    instr_boundary = 1'b1; step(); instr_boundary = 1'b0;
    check("R6 no retake after entry", {31'b0, take_irq}, 32'h0);

    // R9 software enable write loses to entry
    wr(2'd2, 32'h1);
    csr_sel = 2'd2; csr_wdata = 32'h1; csr_we = 1'b1; instr_boundary = 1'b1;
    step(); csr_we = 1'b0; instr_boundary = 1'b0;
    check("R9 entry take", {31'b0, take_irq}, 32'h1);
    rd(2'd2, v); check("R9 entry beats sw write", v, 32'h2);
    step();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule